// File: doc/BRIEF.md
# Byte-Lane Asynchronous DRAM Controller

This block sits between a simple synchronous host port and a 16-bit asynchronous DRAM that has one row strobe, a lower and an upper column strobe, a write enable and an output enable. The host offers one request at a time with a valid/ready handshake: an address, a read/write flag, two byte enables and write data. The controller places the row half and then the column half of the address on a shared address bus, runs a single read or early-write cycle, and for reads returns the word with a one-cycle valid pulse. The DRAM data bus is split into a data-out vector, a per-byte drive enable and a data-in vector. A chip-level pad ring joins them into one bidirectional bus.

After reset the controller stays quiet for a start-up pause of `T_INIT` clocks. It then runs eight column-before-row refreshes and only after that opens the host port. A free-running timer asks for a refresh every `REF_PERIOD` clocks. A pending refresh wins over a waiting host request but never cuts into an access that has already started. All timing is given in clock cycles through parameters. The defaults fit a 200 MHz clock: the pause is 40000 cycles, precharge 10, row hold 2, write/column setup 2, column access 4, refresh strobe lead 2 and refresh row-low time 12.

The state machine has these states. `ST_INIT_WAIT` is the start-up pause. `ST_REF_CAS` asserts both column strobes with the row strobe high. `ST_REF_RAS` asserts the row strobe under them. `ST_PRECHARGE` holds every strobe high. `ST_IDLE` waits for the host. `ST_ROW` opens the row. `ST_COL` sets up the column address and, for a write, drops write enable and drives data. `ST_CAS` asserts the column strobes. The transitions are:
- `ST_INIT_WAIT`→`ST_REF_CAS` when the pause ends.
- `ST_REF_CAS`→`ST_REF_RAS`→`ST_PRECHARGE` for every refresh.
- `ST_PRECHARGE`→`ST_REF_CAS` while fewer than eight start-up refreshes are done, otherwise →`ST_IDLE`.
- `ST_IDLE`→`ST_REF_CAS` when a refresh is pending.
- `ST_IDLE`→`ST_ROW` when a request is accepted.
- `ST_ROW`→`ST_COL`→`ST_CAS`→`ST_PRECHARGE` for every access.

Top module: `dram_byte_ctrl`

## Requirements
- R1: While reset is held and directly after it, the row strobe, both column strobes, write enable and output enable are high (inactive), both byte drive enables are 0, and `req_ready` and `rsp_valid` are 0.
- R2: No strobe falls within the first `T_INIT` clocks after reset is released. Exactly eight refreshes follow before `req_ready` is first 1.
- R3: A refresh drops both column strobes while the row strobe is high, drops the row strobe `T_CSR` clocks later, and keeps write enable high throughout.
- R4: When the host is idle, refreshes start exactly `REF_PERIOD` clocks apart. A pending refresh is served before a waiting request. Every row-strobe rise coincides with a column-strobe rise, so no access or refresh is cut short.
- R5: `req_be[0]` selects the lower strobe and data bits 7:0, and `req_be[1]` selects the upper strobe and bits 15:8. An unselected lane's strobe stays high and that lane is not driven. A request with both enables 0 is carried out as a full-word access.
- R6: The two column strobes fall on the same clock edge and rise on the same clock edge. Neither falls while the other is already low.
- R7: A read keeps write enable high, keeps the drive enables 0, drops output enable with the column strobes, and samples `dram_dq_in` at the clock edge `T_CAC` cycles after the strobes fall. `rsp_valid` is then 1 for exactly one cycle. The bits of an unselected lane in `rsp_rdata` read 0.
- R8: A write is an early write. Write enable falls at least `T_WCS` clocks before the column strobes fall, output enable stays high, and the selected lanes are driven from write-enable fall until the strobes rise. The data bus is never driven while output enable is low.
- R9: The row strobe stays high for at least `T_RP` clocks between any two low periods.
- R10: The row address `req_addr[19:10]` is on `dram_addr` when the row strobe falls. The column address `req_addr[9:0]` is on it when the column strobes fall.
- R11: A request is taken on the clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 while any access or refresh is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Row (upper 10 bits) and column (lower 10 bits) |
| req_be | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data toward the DRAM |
| dram_dq_oe | output | 2 | Per-byte drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
The bench's DRAM model presents read data only from the `T_CAC`-th cycle of column-strobe low and drives a filler pattern otherwise. A controller that samples one cycle early would return the filler bytes. Byte writes followed by full-word and single-lane reads of the same word would expose a lane swap, a strobe dropped on the wrong lane, or an unmasked unselected lane. The model counts the clocks of row-strobe high time, of write-enable lead before the column strobes fall, and of the start-up pause, so a short precharge, a late write enable or an early first strobe appears as a counted violation. It also counts refreshes before the first `req_ready` and measures the spacing of idle refreshes, so a controller that opens the port after seven refreshes, or one whose timer is off by a cycle, is reported.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    typedef enum logic [3:0] {
        ST_INIT_WAIT,
        ST_REF_CAS,
        ST_REF_RAS,
        ST_PRECHARGE,
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_CAS
    } ctrl_state_e;

    localparam int unsigned INIT_REFRESHES = 8;

    // An empty byte-enable mask is treated as a full-word access.
    function automatic logic [1:0] effective_lanes(input logic [1:0] be);
        return (be == 2'b00) ? 2'b11 : be;
    endfunction

endpackage

// File: rtl/dram_wait_counter.sv
module dram_wait_counter #(
    parameter int CNT_W     = 16,
    parameter int RESET_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RESET_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int PERIOD = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic pending
);

    localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

    logic [TW-1:0] tick_q;
    logic          wrap;

    assign wrap = (tick_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q  <= '0;
            pending <= 1'b0;
        end else begin
            tick_q <= wrap ? '0 : tick_q + 1'b1;
            if (wrap) begin
                pending <= 1'b1;
            end else if (clear) begin
                pending <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dram_dq_path.sv
module dram_dq_path #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [LANES-1:0]  lanes_in,
    input  logic              drive,
    input  logic              capture,
    input  logic [DATA_W-1:0] rd_in,
    output logic [LANES-1:0]  lanes,
    output logic [DATA_W-1:0] dq_out,
    output logic [LANES-1:0]  dq_oe,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q   <= '0;
            lanes     <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= capture;
            if (load) begin
                wdata_q <= wdata_in;
                lanes   <= lanes_in;
            end
        end
    end

    assign dq_out = wdata_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dq_oe[g] = drive & lanes[g];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rsp_rdata[g*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rsp_rdata[g*LANE_W +: LANE_W] <= lanes[g] ? rd_in[g*LANE_W +: LANE_W] : '0;
            end
        end
    end

endmodule

// File: rtl/dram_byte_ctrl.sv
module dram_byte_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W      = 10,
    parameter int COL_W      = 10,
    parameter int DATA_W     = 16,
    parameter int T_INIT     = 40000,
    parameter int REF_PERIOD = 1560,
    parameter int T_RP       = 10,
    parameter int T_RAH      = 2,
    parameter int T_WCS      = 2,
    parameter int T_CAC      = 4,
    parameter int T_CSR      = 2,
    parameter int T_REF_RAS  = 12,
    localparam int ADDR_W    = ROW_W + COL_W,
    localparam int MUX_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [MUX_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_lcas_n,
    output logic              dram_ucas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic [1:0]        dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);

    localparam int LANES  = 2;
    localparam int CNT_W  = $clog2(T_INIT + 1);
    localparam int IREF_W = $clog2(INIT_REFRESHES + 1);
    localparam logic [CNT_W-1:0] LD_CSR  = CNT_W'(T_CSR - 1);
    localparam logic [CNT_W-1:0] LD_RREF = CNT_W'(T_REF_RAS - 1);
    localparam logic [CNT_W-1:0] LD_RP   = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_RAH  = CNT_W'(T_RAH - 1);
    localparam logic [CNT_W-1:0] LD_WCS  = CNT_W'(T_WCS - 1);
    localparam logic [CNT_W-1:0] LD_CAC  = CNT_W'(T_CAC - 1);
    localparam logic [IREF_W-1:0] IREF_ALL = IREF_W'(INIT_REFRESHES);

    ctrl_state_e state_q, state_d;

    logic             wait_done, wait_load;
    logic [CNT_W-1:0] wait_val;
    logic             ref_pending, ref_clear;
    logic             accept, capture, drive, init_step;
    logic [IREF_W-1:0] init_refs_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             write_q;
    logic [LANES-1:0] lanes;

    dram_wait_counter #(
        .CNT_W     (CNT_W),
        .RESET_VAL (T_INIT - 1)
    ) i_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (wait_val),
        .done     (wait_done)
    );

    dram_refresh_timer #(
        .PERIOD (REF_PERIOD)
    ) i_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ref_clear),
        .pending (ref_pending)
    );

    dram_dq_path #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) i_dq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .wdata_in  (req_wdata),
        .lanes_in  (effective_lanes(req_be)),
        .drive     (drive),
        .capture   (capture),
        .rd_in     (dram_dq_in),
        .lanes     (lanes),
        .dq_out    (dram_dq_out),
        .dq_oe     (dram_dq_oe),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // State register and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_INIT_WAIT;
            init_refs_q <= '0;
            row_q       <= '0;
            col_q       <= '0;
            write_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (init_step) begin
                init_refs_q <= init_refs_q + 1'b1;
            end
            if (accept) begin
                row_q   <= req_addr[ADDR_W-1:COL_W];
                col_q   <= req_addr[COL_W-1:0];
                write_q <= req_write;
            end
        end
    end

    // Transitions
    always_comb begin
        state_d   = state_q;
        wait_load = 1'b0;
        wait_val  = '0;
        ref_clear = 1'b0;
        accept    = 1'b0;
        capture   = 1'b0;
        init_step = 1'b0;
        unique case (state_q)
            ST_INIT_WAIT: begin
                if (wait_done) begin
                    state_d   = ST_REF_CAS;
                    wait_load = 1'b1;
                    wait_val  = LD_CSR;
                    ref_clear = 1'b1;
                end
            end
            ST_REF_CAS: begin
                if (wait_done) begin
                    state_d   = ST_REF_RAS;
                    wait_load = 1'b1;
                    wait_val  = LD_RREF;
                end
            end
            ST_REF_RAS: begin
                if (wait_done) begin
                    state_d   = ST_PRECHARGE;
                    wait_load = 1'b1;
                    wait_val  = LD_RP;
                    init_step = (init_refs_q < IREF_ALL);
                end
            end
            ST_PRECHARGE: begin
                if (wait_done) begin
                    if (init_refs_q < IREF_ALL) begin
                        state_d   = ST_REF_CAS;
                        wait_load = 1'b1;
                        wait_val  = LD_CSR;
                        ref_clear = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_IDLE: begin
                if (ref_pending) begin
                    state_d   = ST_REF_CAS;
                    wait_load = 1'b1;
                    wait_val  = LD_CSR;
                    ref_clear = 1'b1;
                end else if (req_valid) begin
                    state_d   = ST_ROW;
                    wait_load = 1'b1;
                    wait_val  = LD_RAH;
                    accept    = 1'b1;
                end
            end
            ST_ROW: begin
                if (wait_done) begin
                    state_d   = ST_COL;
                    wait_load = 1'b1;
                    wait_val  = LD_WCS;
                end
            end
            ST_COL: begin
                if (wait_done) begin
                    state_d   = ST_CAS;
                    wait_load = 1'b1;
                    wait_val  = LD_CAC;
                end
            end
            ST_CAS: begin
                if (wait_done) begin
                    state_d   = ST_PRECHARGE;
                    wait_load = 1'b1;
                    wait_val  = LD_RP;
                    capture   = !write_q;
                end
            end
            default: state_d = ST_INIT_WAIT;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        dram_ras_n  = 1'b1;
        dram_lcas_n = 1'b1;
        dram_ucas_n = 1'b1;
        dram_we_n   = 1'b1;
        dram_oe_n   = 1'b1;
        dram_addr   = '0;
        drive       = 1'b0;
        req_ready   = 1'b0;
        unique case (state_q)
            ST_REF_CAS: begin
                dram_lcas_n = 1'b0;
                dram_ucas_n = 1'b0;
            end
            ST_REF_RAS: begin
                dram_ras_n  = 1'b0;
                dram_lcas_n = 1'b0;
                dram_ucas_n = 1'b0;
            end
            ST_IDLE: begin
                req_ready = !ref_pending;
            end
            ST_ROW: begin
                dram_ras_n = 1'b0;
                dram_addr  = MUX_W'(row_q);
            end
            ST_COL: begin
                dram_ras_n = 1'b0;
                dram_addr  = MUX_W'(col_q);
                dram_we_n  = !write_q;
                drive      = write_q;
            end
            ST_CAS: begin
                dram_ras_n  = 1'b0;
                dram_addr   = MUX_W'(col_q);
                dram_lcas_n = !lanes[0];
                dram_ucas_n = !lanes[1];
                dram_we_n   = !write_q;
                dram_oe_n   = write_q;
                drive       = write_q;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/dram_byte_ctrl_checker.sv
module dram_byte_ctrl_checker #(
    parameter int T_RP  = 10,
    parameter int T_WCS = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       ras_n,
    input logic       lcas_n,
    input logic       ucas_n,
    input logic       we_n,
    input logic       oe_n,
    input logic [1:0] dq_oe
);

    localparam int RH_W = $clog2(T_RP + 1);
    localparam int WL_W = $clog2(T_WCS + 1);

    logic [RH_W-1:0] ras_high_q;
    logic [WL_W-1:0] we_lead_q;
    logic [3:0]      cbr_q;
    logic            ras_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_high_q <= '0;
            we_lead_q  <= '0;
            cbr_q      <= '0;
            ras_prev_q <= 1'b1;
        end else begin
            ras_prev_q <= ras_n;
            if (!ras_n) ras_high_q <= '0;
            else if (ras_high_q < RH_W'(T_RP)) ras_high_q <= ras_high_q + 1'b1;
            if (we_n) we_lead_q <= '0;
            else if (lcas_n && ucas_n && we_lead_q < WL_W'(T_WCS)) we_lead_q <= we_lead_q + 1'b1;
            if (ras_prev_q && !ras_n && !lcas_n && !ucas_n && cbr_q < 4'd8) cbr_q <= cbr_q + 1'b1;
        end
    end

    p_port_after_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cbr_q == 4'd8));

    p_cbr_we_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && !lcas_n && !ucas_n) |-> we_n);

    p_no_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> ($rose(lcas_n) || $rose(ucas_n)));

    p_lower_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcas_n) |-> $past(ucas_n));

    p_upper_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ucas_n) |-> $past(lcas_n));

    p_rise_together_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcas_n) |-> ucas_n);

    p_read_bus_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (we_n && dq_oe == 2'b00));

    p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_early_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(lcas_n) || $fell(ucas_n)) && !we_n) |-> (we_lead_q >= WL_W'(T_WCS)));

    p_precharge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (ras_high_q >= RH_W'(T_RP)));

    p_ready_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ras_n && lcas_n && ucas_n));

endmodule

bind dram_byte_ctrl dram_byte_ctrl_checker #(
    .T_RP  (T_RP),
    .T_WCS (T_WCS)
) i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .ras_n     (dram_ras_n),
    .lcas_n    (dram_lcas_n),
    .ucas_n    (dram_ucas_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .dq_oe     (dram_dq_oe)
);

// File: tb/test_dram_byte_ctrl.sv
`timescale 1ns/1ps
module test_dram_byte_ctrl;

    localparam int ROW_W      = 10;
    localparam int COL_W      = 10;
    localparam int T_INIT     = 40000;
    localparam int REF_PERIOD = 1560;
    localparam int T_RP       = 10;
    localparam int T_WCS      = 2;
    localparam int T_CAC      = 4;
    localparam int NVEC       = 11;

    // {write, be[1:0], addr[19:0], wdata[15:0], expected[15:0]}
    localparam logic [54:0] VEC [NVEC] = '{
        {1'b1, 2'b11, 20'h00105, 16'hA1B2, 16'h0000},
        {1'b0, 2'b11, 20'h00105, 16'h0000, 16'hA1B2},
        {1'b1, 2'b01, 20'h00105, 16'h33CC, 16'h0000},
        {1'b0, 2'b11, 20'h00105, 16'h0000, 16'hA1CC},
        {1'b1, 2'b10, 20'h00105, 16'h5566, 16'h0000},
        {1'b0, 2'b10, 20'h00105, 16'h0000, 16'h5500},
        {1'b0, 2'b01, 20'h00105, 16'h0000, 16'h00CC},
        {1'b1, 2'b11, 20'hFFFFF, 16'h0F0F, 16'h0000},
        {1'b0, 2'b11, 20'hFFFFF, 16'h0000, 16'h0F0F},
        {1'b1, 2'b00, 20'h3AC51, 16'h9E71, 16'h0000},
        {1'b0, 2'b11, 20'h3AC51, 16'h0000, 16'h9E71}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [9:0]  dram_addr;
    logic        dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n;
    logic [15:0] dram_dq_out;
    logic [1:0]  dram_dq_oe;
    logic [15:0] dram_dq_in = 16'hEEEE;

    always #2.5 clk = ~clk;

    dram_byte_ctrl #(
        .ROW_W (ROW_W), .COL_W (COL_W), .T_INIT (T_INIT),
        .REF_PERIOD (REF_PERIOD), .T_RP (T_RP), .T_WCS (T_WCS), .T_CAC (T_CAC)
    ) i_dram_byte_ctrl (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_be (req_be), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .dram_addr (dram_addr), .dram_ras_n (dram_ras_n),
        .dram_lcas_n (dram_lcas_n), .dram_ucas_n (dram_ucas_n),
        .dram_we_n (dram_we_n), .dram_oe_n (dram_oe_n),
        .dram_dq_out (dram_dq_out), .dram_dq_oe (dram_dq_oe), .dram_dq_in (dram_dq_in)
    );

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- DRAM model ----------------
    logic [15:0] mem [int];
    int cyc = 0;
    logic ras_p = 1'b1, l_p = 1'b1, u_p = 1'b1;
    int ras_hi_neg = 0, we_lo_neg = 0, cas_neg = 0;
    logic [ROW_W-1:0] row_l = '0;
    logic [COL_W-1:0] col_l = '0;
    int refs = 0, first_act = -1, last_ref_cyc = 0, ref_gap = 0;
    logic [1:0] last_lanes = '0;
    int v_cont = 0, v_early = 0, v_pre = 0, v_cbr_we = 0, v_skew = 0, v_drive = 0;

    always @(posedge clk) if (rst_n) cyc++;

    always @(negedge clk) begin
        if (!rst_n) begin
            ras_p = 1'b1; l_p = 1'b1; u_p = 1'b1;
            ras_hi_neg = 0; we_lo_neg = 0; cas_neg = 0;
        end else begin
            automatic logic l_fall = l_p && !dram_lcas_n;
            automatic logic u_fall = u_p && !dram_ucas_n;
            automatic logic r_fall = ras_p && !dram_ras_n;
            if ((l_fall || u_fall || r_fall) && first_act < 0) first_act = cyc;
            if (r_fall) begin
                if (ras_hi_neg < T_RP) v_pre++;
                if (!dram_lcas_n && !dram_ucas_n) begin
                    refs++;
                    ref_gap = cyc - last_ref_cyc;
                    last_ref_cyc = cyc;
                    if (!dram_we_n) v_cbr_we++;
                end else begin
                    row_l = dram_addr[ROW_W-1:0];
                end
            end
            if ((l_fall && !u_p) || (u_fall && !l_p)) v_skew++;
            if (!dram_oe_n && dram_dq_oe != 2'b00) v_cont++;
            if ((l_fall || u_fall) && !dram_ras_n) begin
                col_l = dram_addr[COL_W-1:0];
                last_lanes = {!dram_ucas_n, !dram_lcas_n};
                if (!dram_we_n) begin
                    automatic int key = int'({row_l, col_l});
                    automatic logic [15:0] w = mem.exists(key) ? mem[key] : 16'h0000;
                    if (we_lo_neg < T_WCS) v_early++;
                    if (dram_dq_oe != last_lanes) v_drive++;
                    if (!dram_lcas_n) w[7:0] = dram_dq_out[7:0];
                    if (!dram_ucas_n) w[15:8] = dram_dq_out[15:8];
                    mem[key] = w;
                end
            end
            ras_hi_neg = dram_ras_n ? ras_hi_neg + 1 : 0;
            we_lo_neg = (!dram_we_n && dram_lcas_n && dram_ucas_n) ? we_lo_neg + 1 : 0;
            cas_neg = (!dram_lcas_n || !dram_ucas_n) ? cas_neg + 1 : 0;
            if (!dram_oe_n && cas_neg >= T_CAC) begin
                automatic int key = int'({row_l, col_l});
                automatic logic [15:0] w = mem.exists(key) ? mem[key] : 16'h0000;
                dram_dq_in = {(!dram_ucas_n ? w[15:8] : 8'hEE), (!dram_lcas_n ? w[7:0] : 8'hEE)};
            end else begin
                dram_dq_in = 16'hEEEE;
            end
            ras_p = dram_ras_n; l_p = dram_lcas_n; u_p = dram_ucas_n;
        end
    end

    // ---------------- host access ----------------
    logic [15:0] rd_word;
    bit rd_got, busy_low, pulse_one;

    task automatic host_access(input logic wr, input logic [1:0] be,
                               input logic [19:0] a, input logic [15:0] wd);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_be = be; req_addr = a; req_wdata = wd;
        n = 0;
        while (!req_ready && n < 5000) begin @(negedge clk); n++; end
        @(negedge clk);
        req_valid = 1'b0;
        busy_low = !req_ready;
        rd_got = 1'b0;
        pulse_one = 1'b0;
        if (!wr) begin
            n = 0;
            while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
            rd_got = rsp_valid;
            rd_word = rsp_rdata;
            @(negedge clk);
            pulse_one = !rsp_valid;
        end
        n = 0;
        while (!req_ready && n < 500) begin @(negedge clk); n++; end
    endtask

    // ---------------- main sequence ----------------
    initial begin
        repeat (4) @(negedge clk);
        // R1: standby state during and after reset
        check(dram_ras_n && dram_lcas_n && dram_ucas_n && dram_we_n && dram_oe_n,
              "R1 strobes high in reset", 32'(dram_ras_n), 32'd1);
        check(dram_dq_oe == 2'b00 && !req_ready && !rsp_valid,
              "R1 bus free and port closed", 32'({dram_dq_oe, req_ready, rsp_valid}), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(dram_ras_n && dram_lcas_n && dram_ucas_n && !req_ready,
              "R1 standby after reset", 32'({dram_ras_n, dram_lcas_n, dram_ucas_n, req_ready}), 32'hE);

        // R2: pause and eight start-up refreshes
        while (!req_ready && cyc < T_INIT + 5000) @(negedge clk);
        check(first_act >= T_INIT, "R2 start-up pause", 32'(first_act), 32'(T_INIT));
        check(refs == 8, "R2 refreshes before ready", 32'(refs), 32'd8);
        check(v_cbr_we == 0, "R3 refresh keeps write enable high", 32'(v_cbr_we), 32'd0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            automatic logic        wr  = VEC[i][54];
            automatic logic [1:0]  be  = VEC[i][53:52];
            automatic logic [19:0] a   = VEC[i][51:32];
            automatic logic [15:0] wd  = VEC[i][31:16];
            automatic logic [15:0] exp = VEC[i][15:0];
            automatic logic [1:0]  eff = (be == 2'b00) ? 2'b11 : be;
            host_access(wr, be, a, wd);
            check(busy_low, "R11 ready low during access", 32'(busy_low), 32'd1);
            check(last_lanes == eff, "R5 strobe lanes", 32'(last_lanes), 32'(eff));
            check(row_l == a[19:10] && col_l == a[9:0], "R10 row/column address",
                  32'({row_l, col_l}), 32'(a));
            if (!wr) begin
                check(rd_got && rd_word == exp, "R7 read data at column-access count",
                      32'(rd_word), 32'(exp));
                check(pulse_one, "R7 single-cycle response", 32'(pulse_one), 32'd1);
            end
        end

        // R4: idle refresh spacing
        begin
            automatic int refs_before = refs;
            repeat (3 * REF_PERIOD + 50) @(negedge clk);
            check(refs - refs_before >= 3, "R4 refreshes while idle", 32'(refs - refs_before), 32'd3);
            check(ref_gap == REF_PERIOD, "R4 refresh spacing", 32'(ref_gap), 32'(REF_PERIOD));
        end

        // Read after refreshes still returns stored data (R4: refresh does not disturb)
        host_access(1'b0, 2'b11, 20'h00105, 16'h0);
        check(rd_word == 16'h55CC, "R4 data kept across refresh", 32'(rd_word), 32'h55CC);

        check(v_skew == 0, "R6 column strobes together", 32'(v_skew), 32'd0);
        check(v_cont == 0, "R8 no drive while output enabled", 32'(v_cont), 32'd0);
        check(v_early == 0, "R8 write enable lead", 32'(v_early), 32'd0);
        check(v_drive == 0, "R8 selected lanes driven", 32'(v_drive), 32'd0);
        check(v_pre == 0, "R9 precharge time", 32'(v_pre), 32'd0);
        check(v_cbr_we == 0, "R3 refresh write enable", 32'(v_cbr_we), 32'd0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule